// File: doc/BRIEF.md
# Channel Status Triple Buffer Manager

This block holds one 24-byte channel-status block in each of three stages. The receive side fills the first stage (D) byte by byte. The host sees and edits the middle stage (E). The transmit side reads the last stage (F). An input block boundary copies D into E. An output block boundary copies E into F. Each boundary is derived by counting frame strobes in its own timebase. Both timebases are carried as strobes in one clock domain.

Each of the two copies has its own inhibit bit, sticky flag and interrupt enable. When the input and output block rates differ, the two copy events drift against each other. A faster output side sends the same E contents in several consecutive blocks. A slower output side lets some input blocks be overwritten in E before they are ever copied on. When byte 0 of the block being copied to F marks professional use, the block computes a check byte and writes it into byte 23 of F in place of whatever E held there.

Top module: `cs_triple_buf`

## Requirements
- R1: After reset, every byte of D, E and F reads 0. The control register and the flags read 0, and `irq` is low.
- R2: `in_block` pulses on every 192nd `in_frame` strobe after reset. On that clock edge E takes the contents of D, and the new E is readable from the next cycle. D written in that same cycle reaches D only.
- R3: `out_block` pulses on every 192nd `out_frame` strobe. On that edge F takes the contents of E, independently of the input side. If both boundaries fall in the same cycle, F receives the E held before that edge.
- R4: Host addresses 0 to 23 read and write E byte for byte. Address 24 is control, with bit0 inhibiting D→E, bit1 inhibiting E→F, bit2 enabling the D→E interrupt and bit3 enabling the E→F interrupt. Address 25 holds the flags, with bit0 for D→E and bit1 for E→F. Other addresses read 0.
- R5: While an inhibit bit is set, the matching boundary changes nothing in the destination buffer and sets no flag.
- R6: A flag is set in the cycle after a copy that is not inhibited. It stays set until the host writes 1 to that bit at address 25. If a set and a clear fall in the same cycle, the set wins.
- R7: `irq` is high exactly when some flag bit and its enable bit are both 1.
- R8: If a host write to E and a D→E copy fall in the same cycle, the written byte takes the host value. Every other byte takes D.
- R9: When bit 0 of byte 0 of E is 1 at an E→F copy, byte 23 of F becomes the check byte over E bytes 0–22. The bits are taken LSB first, with register init 0xFF, polynomial x^8+x^4+x^3+x^2+1 (feedback 0x1D), and shifting out from bit 7. E's byte 23 is then ignored.
- R10: When the frame rates differ, each output boundary sends whatever E holds at that time. Blocks are therefore repeated when the output side is faster and skipped when it is slower.
- R11: `tx_data` shows byte `tx_addr` of F combinationally. Addresses above 23 give 0.
- R12: `rx_we` writes `rx_data` into D byte `rx_addr` at the clock edge. Addresses above 23 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_frame | input | 1 | Frame strobe of the input timebase |
| out_frame | input | 1 | Frame strobe of the output timebase |
| rx_we | input | 1 | Receive-side write enable for D |
| rx_addr | input | 5 | Byte index into D |
| rx_data | input | 8 | Byte written into D |
| host_we | input | 1 | Host write enable |
| host_addr | input | 5 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| tx_addr | input | 5 | Transmit-side byte index into F |
| tx_data | output | 8 | Byte of F (combinational) |
| irq | output | 1 | Interrupt request |
| in_block | output | 1 | Input block boundary strobe |
| out_block | output | 1 | Output block boundary strobe |

## Verification
The block has one register stage between every stimulus and its effect. A copy, a host write, a flag change or a control change driven before a rising edge shows on `host_rdata`, `tx_data` and `irq` right after that edge. The reads themselves are combinational. The bench drives inputs after a falling edge and runs a cycle-level model of D, E, F, control and flags, updated at the same edge. At the next falling edge it checks `irq`. After every cycle with a boundary it sweeps all of E, F, control and flags through the two read ports, in steps of a fraction of a nanosecond while the clock is low.

// File: rtl/cs_buf_pkg.sv
package cs_buf_pkg;

    localparam int CS_BYTES  = 24;
    localparam int ADDR_W    = $clog2(CS_BYTES + 2);
    localparam int CTRL_ADDR = CS_BYTES;
    localparam int STAT_ADDR = CS_BYTES + 1;
    localparam int CRC_BYTE  = CS_BYTES - 1;
    localparam logic [7:0] CRC_POLY = 8'h1D;
    localparam logic [7:0] CRC_INIT = 8'hFF;

    typedef logic [CS_BYTES-1:0][7:0] cs_block_t;

    // bit0 inh_d2e, bit1 inh_e2f, bit2 ie_d2e, bit3 ie_e2f
    typedef struct packed {
        logic ie_e2f;
        logic ie_d2e;
        logic inh_e2f;
        logic inh_d2e;
    } cs_ctrl_t;

    // bit0 d2e, bit1 e2f
    typedef struct packed {
        logic e2f;
        logic d2e;
    } cs_flags_t;

    function automatic logic [7:0] crcc_byte(input logic [7:0] crc, input logic [7:0] data);
        logic [7:0] c;
        logic       fb;
        c = crc;
        for (int b = 0; b < 8; b++) begin
            fb = c[7] ^ data[b];
            c  = {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
        end
        return c;
    endfunction

    function automatic logic [7:0] crcc_block(input cs_block_t blk);
        logic [7:0] c;
        c = CRC_INIT;
        for (int i = 0; i < CRC_BYTE; i++) begin
            c = crcc_byte(c, blk[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/cs_block_timer.sv
module cs_block_timer #(
    parameter int FRAMES = 192
) (
    input  logic clk,
    input  logic rst,
    input  logic frame,
    output logic blk
);
    localparam int CW = (FRAMES > 1) ? $clog2(FRAMES) : 1;
    localparam logic [CW-1:0] LAST = CW'(FRAMES - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST);
    assign blk     = frame && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (frame) begin
            cnt_q <= at_last ? '0 : cnt_q + 1'b1;
        end
    end

    // R2 / R3: the frame count never passes the block length
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst) cnt_q <= LAST);

    // R2 / R3: no frame strobe leaves the count unchanged
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !frame |=> $stable(cnt_q));

endmodule

// File: rtl/cs_tx_image.sv
module cs_tx_image
    import cs_buf_pkg::*;
(
    input  cs_block_t src,
    output cs_block_t img,
    output logic      pro
);
    logic [7:0] crc;

    assign pro = src[0][0];
    assign crc = crcc_block(src);

    always_comb begin
        img = src;
        if (pro) begin
            img[CRC_BYTE] = crc;
        end
    end

endmodule

// File: rtl/cs_triple_buf.sv
module cs_triple_buf
    import cs_buf_pkg::*;
#(
    parameter int FRAMES = 192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_frame,
    input  logic              out_frame,
    input  logic              rx_we,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [7:0]        rx_data,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic [ADDR_W-1:0] tx_addr,
    output logic [7:0]        tx_data,
    output logic              irq,
    output logic              in_block,
    output logic              out_block
);
    localparam logic [ADDR_W-1:0] NB    = ADDR_W'(CS_BYTES);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(STAT_ADDR);

    cs_block_t d_q, e_q, f_q, tx_img;
    cs_ctrl_t  ctrl_q;
    cs_flags_t flags_q, flag_set, flag_clr;
    logic      d2e_go, e2f_go, host_e_wr, img_pro;

    cs_block_timer #(.FRAMES(FRAMES)) u_in_timer (
        .clk(clk), .rst(rst), .frame(in_frame), .blk(in_block));

    cs_block_timer #(.FRAMES(FRAMES)) u_out_timer (
        .clk(clk), .rst(rst), .frame(out_frame), .blk(out_block));

    cs_tx_image u_image (.src(e_q), .img(tx_img), .pro(img_pro));

    assign d2e_go    = in_block  && !ctrl_q.inh_d2e;
    assign e2f_go    = out_block && !ctrl_q.inh_e2f;
    assign host_e_wr = host_we && (host_addr < NB);

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q <= '0;
        end else if (rx_we && (rx_addr < NB)) begin
            d_q[rx_addr] <= rx_data;
        end
    end

    // host byte write placed after the block copy so it wins that byte
    always_ff @(posedge clk) begin
        if (rst) begin
            e_q <= '0;
        end else begin
            if (d2e_go)    e_q <= d_q;
            if (host_e_wr) e_q[host_addr] <= host_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '0;
        end else if (e2f_go) begin
            f_q <= tx_img;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (host_we && (host_addr == A_CTL)) begin
            ctrl_q <= cs_ctrl_t'(host_wdata[3:0]);
        end
    end

    always_comb begin
        flag_set.d2e = d2e_go;
        flag_set.e2f = e2f_go;
        flag_clr     = (host_we && (host_addr == A_STA)) ? cs_flags_t'(host_wdata[1:0]) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~flag_clr) | flag_set;
        end
    end

    assign irq = (flags_q.d2e && ctrl_q.ie_d2e) || (flags_q.e2f && ctrl_q.ie_e2f);

    always_comb begin
        if (host_addr < NB)          host_rdata = e_q[host_addr];
        else if (host_addr == A_CTL) host_rdata = {4'h0, ctrl_q};
        else if (host_addr == A_STA) host_rdata = {6'h0, flags_q};
        else                         host_rdata = 8'h00;
    end

    assign tx_data = (tx_addr < NB) ? f_q[tx_addr] : 8'h00;

    // R5: inhibited copy and no host byte write leave E untouched
    a_r5_hold_e: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.inh_d2e && !host_e_wr) |=> $stable(e_q));

    // R5: E->F inhibit freezes F
    a_r5_hold_f: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.inh_e2f |=> $stable(f_q));

    // R6: a set flag survives cycles without a clear of that bit
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (flags_q.d2e && !flag_clr.d2e) |=> flags_q.d2e);

    // R8: the host byte lands even during a copy
    a_r8_host_wins: assert property (@(posedge clk) disable iff (rst)
        host_e_wr |=> (e_q[$past(host_addr)] == $past(host_wdata)));

    // R9: professional block gets the computed check byte in F
    a_r9_crcc: assert property (@(posedge clk) disable iff (rst)
        (e2f_go && e_q[0][0]) |=> (f_q[CRC_BYTE] == crcc_block($past(e_q))));

    // R3: F changes only at an E->F copy
    a_r3_f_only_on_copy: assert property (@(posedge clk) disable iff (rst)
        !e2f_go |=> $stable(f_q));

endmodule

// File: tb/cs_triple_buf_test.sv
`timescale 1ns/100ps
module cs_triple_buf_test;
    localparam int FR = 192;
    localparam int NB = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_frame = 0, out_frame = 0, rx_we = 0, host_we = 0;
    logic [4:0] rx_addr = 0, host_addr = 0, tx_addr = 0;
    logic [7:0] rx_data = 0, host_wdata = 0;
    logic [7:0] host_rdata, tx_data;
    logic irq, in_block, out_block;

    int vectors = 0;
    int fails = 0;
    string cur = "R1";

    logic [7:0] md [NB];
    logic [7:0] me [NB];
    logic [7:0] mf [NB];
    logic [3:0] mctrl = 0;
    logic [1:0] mflag = 0;
    int icnt = 0, ocnt = 0;

    cs_triple_buf #(.FRAMES(FR)) uut (
        .clk(clk), .rst(rst), .in_frame(in_frame), .out_frame(out_frame),
        .rx_we(rx_we), .rx_addr(rx_addr), .rx_data(rx_data),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .tx_addr(tx_addr), .tx_data(tx_data),
        .irq(irq), .in_block(in_block), .out_block(out_block));

    always #10 clk = ~clk;

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [7:0] b [NB]);
        logic [7:0] r = 8'hFF;
        for (int i = 0; i < NB - 1; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic top = r[7] ^ b[i][j];
                r = r << 1;
                if (top) r = r ^ 8'h1D;
            end
        end
        return r;
    endfunction

    task automatic sweep();
        for (int i = 0; i < NB; i++) begin
            host_addr = 5'(i);
            tx_addr = 5'(i);
            #0.2;
            chk(host_rdata, me[i], cur);
            chk(tx_data, mf[i], {cur, "/R11"});
        end
        tx_addr = 5'd27;
        host_addr = 5'd24;
        #0.2;
        chk(host_rdata, {4'h0, mctrl}, "R4");
        chk(tx_data, 8'h00, "R11");
        host_addr = 5'd25;
        #0.2;
        chk(host_rdata, {6'h0, mflag}, "R6");
        host_addr = 5'd30;
        #0.2;
        chk(host_rdata, 8'h00, "R4");
    endtask

    task automatic step(input bit fi, input bit fo, input bit rw, input int ra,
                        input logic [7:0] rd, input bit hw, input int ha, input logic [7:0] hd);
        logic [7:0] nd [NB];
        logic [7:0] ne [NB];
        logic [7:0] nf [NB];
        logic [1:0] clr;
        bit ib, ob, d2e, e2f;
        in_frame = fi; out_frame = fo;
        rx_we = rw; rx_addr = 5'(ra); rx_data = rd;
        host_we = hw; host_addr = 5'(ha); host_wdata = hd;
        ib = fi && (icnt == FR - 1);
        ob = fo && (ocnt == FR - 1);
        d2e = ib && !mctrl[0];
        e2f = ob && !mctrl[1];
        nd = md; ne = me; nf = mf;
        if (rw && ra < NB) nd[ra] = rd;
        if (d2e) ne = md;
        if (hw && ha < NB) ne[ha] = hd;
        if (e2f) begin
            nf = me;
            if (me[0][0]) nf[NB-1] = ref_crc(me);
        end
        clr = (hw && ha == 25) ? hd[1:0] : 2'b00;
        @(posedge clk);
        md = nd; me = ne; mf = nf;
        if (hw && ha == 24) mctrl = hd[3:0];
        mflag = (mflag & ~clr) | {e2f, d2e};
        if (fi) icnt = (icnt == FR - 1) ? 0 : icnt + 1;
        if (fo) ocnt = (ocnt == FR - 1) ? 0 : ocnt + 1;
        @(negedge clk);
        in_frame = 0; out_frame = 0; rx_we = 0; host_we = 0;
        #0.2;
        chk({7'h0, irq}, {7'h0, |(mflag & mctrl[3:2])}, "R7");
        if (ib || ob) sweep();
    endtask

    task automatic run(input bit fi, input bit fo, input int n);
        for (int k = 0; k < n; k++) step(fi, fo, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic load_d(input int seed);
        for (int k = 0; k < NB; k++) step(0, 0, 1, k, 8'(k * 7 + seed), 0, 0, 0);
    endtask

    task automatic hwr(input int a, input logic [7:0] v);
        step(0, 0, 0, 0, 0, 1, a, v);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) begin md[i] = 0; me[i] = 0; mf[i] = 0; end
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur = "R1";
        chk({7'h0, irq}, 8'h00, "R1");
        sweep();

        cur = "R12";
        load_d(2);
        step(0, 0, 1, 29, 8'hEE, 0, 0, 0);
        cur = "R2";
        run(1, 0, FR);

        hwr(24, 8'h0C);
        cur = "R6";
        hwr(25, 8'h01);
        sweep();

        cur = "R3";
        run(0, 1, FR);

        cur = "R9";
        hwr(0, 8'h01);
        hwr(23, 8'h55);
        run(0, 1, FR);
        hwr(0, 8'hA3);
        run(0, 1, FR);

        cur = "R5";
        hwr(24, 8'h0D);
        load_d(9);
        run(1, 0, FR);
        hwr(24, 8'h0F);
        hwr(4, 8'h44);
        run(0, 1, FR);
        hwr(24, 8'h0E);
        run(0, 1, FR);

        cur = "R8";
        hwr(24, 8'h0C);
        load_d(5);
        run(1, 0, FR - 1);
        step(1, 0, 0, 0, 0, 1, 5, 8'h99);
        step(0, 0, 0, 0, 0, 1, 25, 8'h03);
        step(1, 1, 0, 0, 0, 1, 25, 8'h03);

        cur = "R10";
        for (int k = 0; k < 3 * FR; k++)
            step(k % 3 != 0, 1, 1, k % NB, 8'(k * 13 + 1), 0, 0, 0);
        for (int k = 0; k < 3 * FR; k++)
            step(1, k % 3 != 0, 1, k % NB, 8'(k * 5 + 3), (k % 50) == 7, 25, 8'h03);
        sweep();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule